// File: doc/BRIEF.md
# Token-Passing Cell Readout Multiplexer

This block drains a bank of already-digitized storage cells onto one shared output bus. Every cell presents a latched 12-bit conversion code. The cells are not selected through a wide address decoder. Instead, one token circulates around a ring of per-cell flops, and only the cell that holds the token places its code on the bus. A start pulse, accepted only while the block is idle, drops the token into the ring. The token then moves one position on every read-clock edge, so exactly one word leaves per read-clock period. Each word carries a channel tag and a cell tag beside the code.

The default geometry is four channels of 256 cells, which gives 1024 positions. Positions are numbered channel-major: linear index = channel × cells-per-channel + cell. In full mode the scan starts at position 0 and covers every position. The block is used once conversion of a capture has finished, and sampling of the next capture may run in parallel with the scan.

A region-of-interest mode injects the token at a chosen position and limits the scan to a chosen number of words. When the scan passes the highest position it wraps to position 0. After the last word, the token is removed from the ring and a one-cycle done pulse is raised.

Top module: `token_readout_mux`

## Requirements
- R1: After reset is released, bus_valid_o and scan_done_o are low and they stay low until a start is accepted.
- R2: No more than one ring position holds the token in any cycle. While bus_valid_o is high, bus_data_o equals the 12-bit code of the holder: bits [12*i+11 : 12*i] of cell_words_i for holder i.
- R3: A start accepted at a read-clock edge makes the first word valid in the cycle that follows that edge. Each later cycle of the scan presents the next linear index, and no cycle of the scan lacks a word.
- R4: With roi_en_i low, a start scans all 1024 positions in order from index 0 and ignores roi_start_i and roi_len_i. For each word, bus_ch_o = index / 256 and bus_cell_o = index mod 256.
- R5: In the cycle right after the last word, scan_done_o is high for exactly one cycle and bus_valid_o is low.
- R6: A start that arrives while a word is valid is ignored. The running scan keeps its order and its length.
- R7: With roi_en_i high, the scan begins at index roi_start_i and emits roi_len_i words. The index after 1023 is 0.
- R8: With roi_en_i high, a roi_len_i of 0, or any value above 1024, produces a scan of 1024 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rd | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Scan request, sampled on the read clock |
| roi_en_i | input | 1 | Selects region-of-interest mode |
| roi_start_i | input | 10 | First linear index in region mode |
| roi_len_i | input | 11 | Word count in region mode |
| cell_words_i | input | 12288 | Latched codes, 12 bits per linear index |
| bus_data_o | output | 12 | Code of the token holder |
| bus_ch_o | output | 2 | Channel tag of the current word |
| bus_cell_o | output | 8 | Cell tag of the current word |
| bus_valid_o | output | 1 | A word is on the bus |
| scan_done_o | output | 1 | One-cycle pulse after the last word |

## Verification
The bench checks the wrap from index 1023 to 0 in region mode. A design that broke the ring at the top would emit nothing after 1023, or would jump to some other index. It also sends a start in the middle of a scan with a different start index. A design that reloaded on that start would restart at the new index, or would end up holding two tokens. Lengths of 0, 1 and above 1024 are tried, because an off-by-one or unclipped counter would add a word, drop one, or run past 1024. Every scan ends with a check that done appears exactly one cycle after the last word and does not repeat.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

  // Next position around a ring of 'total' positions.
  function automatic int unsigned ring_inc(input int unsigned i, input int unsigned total);
    return (i + 1 >= total) ? 0 : i + 1;
  endfunction

  // Previous position around a ring of 'total' positions.
  function automatic int unsigned ring_prev(input int unsigned i, input int unsigned total);
    return (i == 0) ? total - 1 : i - 1;
  endfunction

endpackage

// File: rtl/rdo_scan_ctrl.sv
module rdo_scan_ctrl #(
  parameter int TOTAL  = 1024,
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              roi_en_i,
  input  logic [ADDR_W-1:0] roi_start_i,
  input  logic [LEN_W-1:0]  roi_len_i,
  output logic              load_o,
  output logic              shift_o,
  output logic              kill_o,
  output logic [ADDR_W-1:0] start_idx_o,
  output logic              scanning_o,
  output logic              done_o
);

  localparam logic [LEN_W-1:0]  TOTAL_L = LEN_W'(TOTAL);
  localparam logic [ADDR_W:0]   TOTAL_X = (ADDR_W+1)'(TOTAL);

  logic [LEN_W-1:0] rem_q, rem_d;
  logic             rem_en;
  logic             done_q, done_d;
  logic [LEN_W-1:0] eff_len;
  logic [ADDR_W:0]  start_x;
  logic             last;

  // Effective length and start index
  always_comb begin
    if (!roi_en_i || roi_len_i == '0 || roi_len_i > TOTAL_L) eff_len = TOTAL_L;
    else                                                      eff_len = roi_len_i;
    start_x = roi_en_i ? {1'b0, roi_start_i} : '0;
    if (start_x >= TOTAL_X) start_x = start_x - TOTAL_X;
  end

  // Next-state logic
  always_comb begin
    scanning_o  = (rem_q != '0);
    last        = (rem_q == LEN_W'(1));
    load_o      = start_i && !scanning_o;
    shift_o     = scanning_o;
    kill_o      = last;
    start_idx_o = start_x[ADDR_W-1:0];
    rem_en      = load_o || scanning_o;
    rem_d       = load_o ? eff_len : (rem_q - LEN_W'(1));
    done_d      = last;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (rem_en) rem_q <= rem_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  assert_len_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= TOTAL_L);

  assert_busy_no_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning_o && start_i) |=> (rem_q == $past(rem_q) - LEN_W'(1)));

endmodule

// File: rtl/rdo_token_ring.sv
module rdo_token_ring #(
  parameter int TOTAL  = 1024,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              kill_i,
  input  logic [ADDR_W-1:0] start_idx_i,
  output logic [TOTAL-1:0]  token_o
);
  import rdo_pkg::*;

  logic [TOTAL-1:0] tok_q, tok_d;
  logic             tok_en;

  assign tok_en = load_i || shift_i || kill_i;

  for (genvar i = 0; i < TOTAL; i++) begin : g_pos
    localparam int PREV = int'(ring_prev(i, TOTAL));
    always_comb begin
      if (kill_i)       tok_d[i] = 1'b0;
      else if (load_i)  tok_d[i] = (start_idx_i == ADDR_W'(i));
      else if (shift_i) tok_d[i] = tok_q[PREV];
      else              tok_d[i] = tok_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tok_q[i] <= 1'b0;
      else if (tok_en) tok_q[i] <= tok_d[i];
    end
  end

  assign token_o = tok_q;

  assert_single_token_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tok_q));

endmodule

// File: rtl/rdo_bus_merge.sv
module rdo_bus_merge #(
  parameter int TOTAL  = 1024,
  parameter int WORD_W = 12,
  parameter int ADDR_W = 10
) (
  input  logic [TOTAL-1:0]        token_i,
  input  logic [TOTAL*WORD_W-1:0] words_i,
  output logic [WORD_W-1:0]       data_o,
  output logic [ADDR_W-1:0]       idx_o,
  output logic                    any_o
);

  // Only the holder contributes; all others are gated to zero.
  always_comb begin
    data_o = '0;
    idx_o  = '0;
    for (int i = 0; i < TOTAL; i++) begin
      if (token_i[i]) begin
        data_o = data_o | words_i[i*WORD_W +: WORD_W];
        idx_o  = idx_o  | ADDR_W'(i);
      end
    end
    any_o = |token_i;
  end

endmodule

// File: rtl/token_readout_mux.sv
module token_readout_mux #(
  parameter int NUM_CH    = 4,
  parameter int NUM_CELLS = 256,
  parameter int WORD_W    = 12,
  localparam int TOTAL    = NUM_CH * NUM_CELLS,
  localparam int ADDR_W   = (TOTAL > 1) ? $clog2(TOTAL) : 1,
  localparam int LEN_W    = $clog2(TOTAL + 1),
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CELL_W   = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic                    clk_rd,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    roi_en_i,
  input  logic [ADDR_W-1:0]       roi_start_i,
  input  logic [LEN_W-1:0]        roi_len_i,
  input  logic [TOTAL*WORD_W-1:0] cell_words_i,
  output logic [WORD_W-1:0]       bus_data_o,
  output logic [CH_W-1:0]         bus_ch_o,
  output logic [CELL_W-1:0]       bus_cell_o,
  output logic                    bus_valid_o,
  output logic                    scan_done_o
);
  import rdo_pkg::*;

  // Reset: asserted asynchronously, released on the read clock
  logic rst_m_q, rst_s_n;
  always_ff @(posedge clk_rd or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_n <= rst_m_q;
    end
  end

  logic              load, shift, kill, scanning;
  logic [ADDR_W-1:0] start_idx, hold_idx;
  logic [TOTAL-1:0]  token;

  rdo_scan_ctrl #(.TOTAL(TOTAL), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk_rd), .rst_n(rst_s_n), .start_i(start_i), .roi_en_i(roi_en_i),
    .roi_start_i(roi_start_i), .roi_len_i(roi_len_i), .load_o(load),
    .shift_o(shift), .kill_o(kill), .start_idx_o(start_idx),
    .scanning_o(scanning), .done_o(scan_done_o)
  );

  rdo_token_ring #(.TOTAL(TOTAL), .ADDR_W(ADDR_W)) u_ring (
    .clk(clk_rd), .rst_n(rst_s_n), .load_i(load), .shift_i(shift),
    .kill_i(kill), .start_idx_i(start_idx), .token_o(token)
  );

  rdo_bus_merge #(.TOTAL(TOTAL), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_merge (
    .token_i(token), .words_i(cell_words_i), .data_o(bus_data_o),
    .idx_o(hold_idx), .any_o(bus_valid_o)
  );

  // Channel-major split of the linear index
  always_comb begin
    bus_ch_o   = CH_W'(int'(hold_idx) / NUM_CELLS);
    bus_cell_o = CELL_W'(int'(hold_idx) % NUM_CELLS);
  end

  assert_valid_tracks_scan_R3: assert property (@(posedge clk_rd) disable iff (!rst_s_n)
    bus_valid_o == scanning);

  assert_token_advances_R3: assert property (@(posedge clk_rd) disable iff (!rst_s_n)
    (bus_valid_o && $past(bus_valid_o)) |->
      (hold_idx == ADDR_W'(ring_inc(32'($past(hold_idx)), TOTAL))));

  assert_done_after_last_R5: assert property (@(posedge clk_rd) disable iff (!rst_s_n)
    scan_done_o |-> (!bus_valid_o && $past(bus_valid_o)));

  assert_done_single_R5: assert property (@(posedge clk_rd) disable iff (!rst_s_n)
    scan_done_o |=> !scan_done_o);

  assert_busy_start_ignored_R6: assert property (@(posedge clk_rd) disable iff (!rst_s_n)
    (bus_valid_o && start_i && !kill) |=>
      (bus_valid_o && hold_idx == ADDR_W'(ring_inc(32'($past(hold_idx)), TOTAL))));

endmodule

// File: tb/tb_token_readout_mux.sv
module tb_token_readout_mux;
  localparam int NCH = 4, NCELL = 256, WW = 12;
  localparam int TOTAL = NCH * NCELL;
  localparam int AW = 10, LW = 11;

  logic clk = 1'b0;
  logic rst_n;
  logic start, roi_en;
  logic [AW-1:0] roi_start;
  logic [LW-1:0] roi_len;
  logic [TOTAL*WW-1:0] words;
  logic [WW-1:0] bus_data;
  logic [1:0] bus_ch;
  logic [7:0] bus_cell;
  logic bus_valid, done;

  int n_cmp = 0, n_bad = 0;
  int salt = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  token_readout_mux dut (
    .clk_rd(clk), .rst_n(rst_n), .start_i(start), .roi_en_i(roi_en),
    .roi_start_i(roi_start), .roi_len_i(roi_len), .cell_words_i(words),
    .bus_data_o(bus_data), .bus_ch_o(bus_ch), .bus_cell_o(bus_cell),
    .bus_valid_o(bus_valid), .scan_done_o(done)
  );

  function automatic int pat(input int idx);
    return (idx * 37 + salt * 113 + 5) & 12'hFFF;
  endfunction

  task automatic fill_words();
    salt = salt + 1 + int'($urandom % 7);
    for (int i = 0; i < TOTAL; i++) words[i*WW +: WW] = WW'(pat(i));
  endtask

  task automatic check(input bit ok, input string req, input string msg);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // One scan: expect nexp words from index first; optionally a busy start at word 3.
  task automatic do_scan(input bit roi, input int sa, input int len,
                         input int first, input int nexp, input bit busy_start,
                         input string req);
    @(negedge clk);
    fill_words();
    roi_en = roi; roi_start = AW'(sa); roi_len = LW'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < nexp; j++) begin
      int idx;
      bit ok;
      idx = (first + j) % TOTAL;
      ok = bus_valid && bus_data == WW'(pat(idx)) && int'(bus_ch) == idx / NCELL
           && int'(bus_cell) == idx % NCELL && !done;
      check(ok, req, $sformatf("word %0d got v=%0b d=%03h ch=%0d cell=%0d exp d=%03h ch=%0d cell=%0d",
            j, bus_valid, bus_data, bus_ch, bus_cell, pat(idx), idx / NCELL, idx % NCELL));
      if (busy_start && j == 3) begin
        start = 1'b1; roi_start = AW'((sa + 300) % TOTAL); roi_len = LW'(2);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(done && !bus_valid, "R5",
          $sformatf("end of scan got done=%0b valid=%0b exp done=1 valid=0", done, bus_valid));
    @(negedge clk);
    check(!done && !bus_valid, "R5",
          $sformatf("after done got done=%0b valid=%0b exp 0 0", done, bus_valid));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got hung run exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; start = 1'b0; roi_en = 1'b0; roi_start = '0; roi_len = '0;
    words = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle after reset
    check(!bus_valid && !done, "R1",
          $sformatf("got valid=%0b done=%0b exp 0 0", bus_valid, done));
    // R1: a start during reset synchronization has nothing to undo; still idle
    @(negedge clk);
    check(!bus_valid && !done, "R1",
          $sformatf("idle hold got valid=%0b done=%0b exp 0 0", bus_valid, done));

    // R4 full scan, ROI fields set to junk that must be ignored
    do_scan(1'b0, 700, 5, 0, TOTAL, 1'b0, "R4");
    // R7 wrap past the top index
    do_scan(1'b1, 1020, 10, 1020, 10, 1'b0, "R7");
    // R7 single word at the last index
    do_scan(1'b1, 1023, 1, 1023, 1, 1'b0, "R7");
    // R6 start while busy is ignored
    do_scan(1'b1, 40, 20, 40, 20, 1'b1, "R6");
    // R8 zero length means full count
    do_scan(1'b1, 500, 0, 500, TOTAL, 1'b0, "R8");
    // R8 oversize length clipped
    do_scan(1'b1, 7, 2000, 7, TOTAL, 1'b0, "R8");
    // R2/R3 random regions
    for (int k = 0; k < 8; k++) begin
      int sa, ln;
      sa = int'($urandom % TOTAL);
      ln = 1 + int'($urandom % 40);
      do_scan(1'b1, sa, ln, sa, ln, 1'b0, "R2_R3");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule